// File: doc/BRIEF.md
# Audio Transmit FIFO Register Front End

This block sits between a processor bus and a stereo serial audio transmitter. Software reaches it through a small map of 32-bit registers at word stride. There are four registers:

- a fixed identification word,
- a configuration word,
- a two-bit interrupt mask,
- a two-bit sticky status word.

Four further offsets act as write-only data ports. Every write to any of them appends one 32-bit sample word to an internal FIFO. Software writes the left word of a frame first and then the right word. The downstream serializer pulls words with a valid/ready pair and reads its control fields straight from the configuration outputs.

Two conditions are tracked: the FIFO is empty (underrun), and its occupancy is below a trigger threshold. The threshold is the depth divided by a power of two, chosen by a 4-bit code in the configuration word. Each condition sets a sticky status bit. Writing a 1 to that bit clears it, and the bit sets again if the condition persists. A single interrupt line is raised when interrupts are globally enabled and a set status bit is also unmasked.

Top module: `audio_tx_regfile`

## Requirements
- R1: After reset the configuration and mask registers read 0 and `smp_valid` is low.
- R2: Offset 0x00 reads the `VERSION` parameter, and writes to it are ignored. Offsets 0x10–0x1C (data ports) and any offset at or above 0x20 read 0. Read data appears on `reg_rdata` one cycle after `reg_rd`.
- R3: The configuration register at 0x04 stores only its defined fields, and all other bits read 0 (writable mask 0xFF3FFF07). The fields are:
  - bit 0: transmit enable, driven on `tx_en`;
  - bit 1: interrupt enable;
  - bit 2: left-first flag, driven on `left_first`;
  - bits 15:8: clock ratio, driven on `clk_ratio`;
  - bits 21:16: sample resolution, driven on `sample_res`;
  - bits 27:24: level code;
  - bits 31:28: channel field, driven on `chan_cfg`.
- R4: Words written to the data ports leave on `smp_data` in write order. A word is removed in each cycle where `smp_valid` and `smp_ready` are both high, and `smp_valid` is high exactly when the FIFO is non-empty.
- R5: A data-port write while the FIFO holds `DEPTH` words is dropped, and the stored words are unchanged. `DEPTH` must be a power of two.
- R6: Status bit 0 (underrun) sets while the FIFO is empty. Status bit 1 (level) sets while occupancy is below `DEPTH >> code`. Code 0 gives threshold 0, so bit 1 never sets.
- R7: Writing 1 to a status bit at 0x0C clears it, and it sets again on the following cycle if its condition still holds. Writing 0 leaves the bit unchanged.
- R8: `irq` is high exactly when the interrupt-enable bit is set and (status AND mask) is non-zero. The mask at 0x08 uses bit 0 for underrun and bit 1 for level.
- R9: A push and a pop in the same cycle both take effect, and the FIFO occupancy is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | AW | Byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| smp_data | output | 32 | FIFO head word |
| smp_valid | output | 1 | FIFO non-empty |
| smp_ready | input | 1 | Serializer takes head word |
| tx_en | output | 1 | Transmit enable field |
| left_first | output | 1 | Left-first flag field |
| clk_ratio | output | 8 | Clock ratio field |
| sample_res | output | 6 | Sample resolution field |
| chan_cfg | output | 4 | Channel field |
| irq | output | 1 | Interrupt request |

## Verification
A data-port push and a serializer pop can land in the same cycle. So can a full-FIFO push and a pending pop. The bench provokes the first case by holding `smp_ready` high while it streams back-to-back data-port writes into a partly filled FIFO. It provokes the drop by bursting `DEPTH + 2` writes with `smp_ready` low. A scoreboard queue models occupancy alongside the design and accepts a pushed word only while the model is below `DEPTH`. Each popped word is then compared in order, and any lost, duplicated or reordered word shows up as a mismatch or as a non-empty queue at the end.

// File: rtl/audio_tx_regfile.sv
module audio_tx_regfile #(
  parameter int          DEPTH   = 256,
  parameter int          AW      = 8,
  parameter logic [31:0] VERSION = 32'h0001_0200
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [AW-1:0] reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic [31:0]   smp_data,
  output logic          smp_valid,
  input  logic          smp_ready,
  output logic          tx_en,
  output logic          left_first,
  output logic [7:0]    clk_ratio,
  output logic [5:0]    sample_res,
  output logic [3:0]    chan_cfg,
  output logic          irq
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;
  localparam logic [31:0]   CFG_MASK = 32'hFF3F_FF07;
  localparam logic [CW-1:0] DEPTH_C  = CW'(DEPTH);

  logic [31:0]   mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] count, thr;
  logic [31:0]   cfg;
  logic [1:0]    mask, sts, cond;

  wire       in_map  = (reg_addr[AW-1:5] == '0);
  wire [2:0] word    = reg_addr[4:2];
  wire       wr_cfg  = reg_wr && in_map && word == 3'd1;
  wire       wr_mask = reg_wr && in_map && word == 3'd2;
  wire       wr_ack  = reg_wr && in_map && word == 3'd3;
  wire       push    = reg_wr && in_map && word[2] && count != DEPTH_C;
  wire       pop     = smp_ready && count != '0;
  wire [3:0] code    = cfg[27:24];

  assign thr  = (code == 4'd0) ? '0 : (DEPTH_C >> code);
  assign cond = {count < thr, count == '0};

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= reg_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; count <= '0;
      cfg <= '0; mask <= '0; sts <= '0; reg_rdata <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
      count <= count + CW'(push) - CW'(pop);
      if (wr_cfg)  cfg  <= reg_wdata & CFG_MASK;
      if (wr_mask) mask <= reg_wdata[1:0];
      sts <= (sts | cond) & ~(wr_ack ? reg_wdata[1:0] : 2'b00);
      if (reg_rd) begin
        if (!in_map) reg_rdata <= '0;
        else case (word)
          3'd0:    reg_rdata <= VERSION;
          3'd1:    reg_rdata <= cfg;
          3'd2:    reg_rdata <= {30'd0, mask};
          3'd3:    reg_rdata <= {30'd0, sts};
          default: reg_rdata <= '0;
        endcase
      end
    end
  end

  assign smp_data   = mem[rp];
  assign smp_valid  = count != '0;
  assign tx_en      = cfg[0];
  assign left_first = cfg[2];
  assign clk_ratio  = cfg[15:8];
  assign sample_res = cfg[21:16];
  assign chan_cfg   = cfg[31:28];
  assign irq        = cfg[1] && |(sts & mask);
endmodule

module audio_tx_regfile_chk #(
  parameter int DEPTH = 256,
  parameter int AW    = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     reg_wr,
  input logic [AW-1:0]            reg_addr,
  input logic [31:0]              reg_wdata,
  input logic                     smp_valid,
  input logic                     smp_ready,
  input logic                     irq,
  input logic [$clog2(DEPTH):0]   count,
  input logic [1:0]               sts
);
  wire ack0 = reg_wr && reg_addr == AW'(12) && reg_wdata[0];

  p_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    count <= ($clog2(DEPTH)+1)'(DEPTH));
  p_full_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (count == ($clog2(DEPTH)+1)'(DEPTH) && !smp_ready) |=> count == ($clog2(DEPTH)+1)'(DEPTH));
  p_valid_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0) |-> !smp_valid);
  p_underrun_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0 && !ack0) |=> sts[0]);
  p_ack_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ack0 |=> !sts[0]);
  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sts[0] && !ack0) |=> sts[0]);
  p_irq_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (sts != 2'b00));
endmodule

bind audio_tx_regfile audio_tx_regfile_chk #(.DEPTH(DEPTH), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .smp_valid(smp_valid), .smp_ready(smp_ready),
  .irq(irq), .count(count), .sts(sts)
);

// File: tb/audio_tx_regfile_tb.sv
module audio_tx_regfile_tb;
  localparam int DEPTH = 16;
  localparam int AW = 8;
  localparam logic [31:0] VER = 32'hC0DE_0102;

  logic clk = 0, rst_n = 0, reg_wr = 0, reg_rd = 0, smp_ready = 0;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata, smp_data;
  logic smp_valid, tx_en, left_first, irq;
  logic [7:0] clk_ratio;
  logic [5:0] sample_res;
  logic [3:0] chan_cfg;

  int checks = 0, fails = 0, mcount = 0;
  logic [31:0] exp_q[$];
  logic [31:0] rv;

  always #5 clk = ~clk;

  audio_tx_regfile #(.DEPTH(DEPTH), .AW(AW), .VERSION(VER)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .smp_data(smp_data), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .tx_en(tx_en), .left_first(left_first), .clk_ratio(clk_ratio),
    .sample_res(sample_res), .chan_cfg(chan_cfg), .irq(irq));

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(posedge clk); #1; reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1; reg_wr = 0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(posedge clk); #1; reg_rd = 1; reg_addr = a;
    @(posedge clk); #1; reg_rd = 0; d = reg_rdata;
  endtask

  task automatic push_burst(input int n, input logic [31:0] base);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      reg_wr = 1; reg_addr = AW'(16 + 4 * (i % 4)); reg_wdata = base + 32'(i);
      if (mcount < DEPTH) begin exp_q.push_back(base + 32'(i)); mcount++; end
    end
    @(posedge clk); #1; reg_wr = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // monitor: scoreboard pop and compare (R4, R5, R9)
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && smp_valid && smp_ready) begin
        if (exp_q.size() == 0) chk(smp_data, 32'hxxxx_xxxx, "R4 unexpected word");
        else chk(smp_data, exp_q.pop_front(), "R4 order");
        mcount--;
      end
    end
  end

  initial begin
    #(200000 * 10);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    idle(3); rst_n = 1; idle(2);
    // R1 reset state
    rd(8'h04, rv); chk(rv, 0, "R1 cfg");
    rd(8'h08, rv); chk(rv, 0, "R1 mask");
    @(negedge clk); chk(32'(smp_valid), 0, "R1 valid");
    rd(8'h0C, rv); chk(rv, 32'h1, "R6 underrun only, code 0");
    // R2 decode
    rd(8'h00, rv); chk(rv, VER, "R2 version");
    wr(8'h00, 32'h1234_5678); rd(8'h00, rv); chk(rv, VER, "R2 version write ignored");
    rd(8'h14, rv); chk(rv, 0, "R2 data port reads 0");
    rd(8'h40, rv); chk(rv, 0, "R2 unmapped reads 0");
    // R3 config fields
    wr(8'h04, 32'hFFFF_FFFF); rd(8'h04, rv); chk(rv, 32'hFF3F_FF07, "R3 writable mask");
    wr(8'h04, 32'hA53C_5A05); rd(8'h04, rv); chk(rv, 32'hA53C_5A05, "R3 readback");
    @(negedge clk);
    chk({tx_en, left_first, clk_ratio, sample_res, chan_cfg},
        {1'b1, 1'b1, 8'h5A, 6'h3C, 4'hA}, "R3 field outputs");
    // R4 in-order flow
    wr(8'h04, 32'h0);
    push_burst(5, 32'hA000_0000);
    idle(2); smp_ready = 1; idle(10); smp_ready = 0;
    chk(32'(exp_q.size()), 0, "R4 drained");
    // R6 level with code 2 (threshold 4)
    wr(8'h04, 32'h0200_0000);
    push_burst(3, 32'hB000_0000); idle(2);
    wr(8'h0C, 32'h3); idle(2);
    rd(8'h0C, rv); chk(rv, 32'h2, "R6 level below threshold");
    push_burst(1, 32'hB000_0003); idle(2);
    wr(8'h0C, 32'h3); idle(2);
    rd(8'h0C, rv); chk(rv, 32'h0, "R7 ack with conditions gone");
    smp_ready = 1; idle(8); smp_ready = 0; idle(2);
    rd(8'h0C, rv); chk(rv, 32'h3, "R6 empty sets both");
    // R7 write 0 no effect, ack re-sets while empty
    wr(8'h0C, 32'h0); rd(8'h0C, rv); chk(rv, 32'h3, "R7 write 0 keeps bits");
    wr(8'h0C, 32'h1); idle(1); rd(8'h0C, rv); chk(rv, 32'h3, "R7 re-set while condition holds");
    // R8 interrupt gating
    wr(8'h08, 32'h0); wr(8'h04, 32'h0200_0002);
    @(negedge clk); chk(32'(irq), 0, "R8 masked");
    wr(8'h08, 32'h1); @(negedge clk); chk(32'(irq), 1, "R8 unmasked");
    wr(8'h04, 32'h0200_0000); @(negedge clk); chk(32'(irq), 0, "R8 global disable");
    wr(8'h08, 32'h0);
    // R5 overflow drop
    push_burst(DEPTH + 2, 32'hC000_0000); idle(2);
    chk(32'(exp_q.size()), DEPTH, "R5 model full");
    wr(8'h0C, 32'h3); idle(2);
    rd(8'h0C, rv); chk(rv, 32'h0, "R5 full clears status");
    smp_ready = 1; idle(DEPTH + 4); smp_ready = 0;
    chk(32'(exp_q.size()), 0, "R5 stored words intact");
    // R9 concurrent push and pop
    push_burst(3, 32'hD000_0000);
    smp_ready = 1;
    push_burst(6, 32'hD000_0010);
    idle(20); smp_ready = 0;
    chk(32'(exp_q.size()), 0, "R9 all words delivered");
    @(negedge clk); chk(32'(smp_valid), 0, "R9 empty after drain");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule